// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Gated Pullups

This block is one general-purpose I/O port of eight pins. Software reaches it through a small synchronous register bus with an address, a write strobe, write data and combinational read data. Five registers sit behind that bus: an output latch, a direction mask, a pullup mask, and two plain storage masks for slew-rate and drive-strength selection that go straight out to the pads.

Per pin, the port drives an output enable, an output value and a pullup enable. A pin can be taken over by a shared peripheral, whose enable and value then replace the port's own, or by an analog function. The pullup is switched off whenever the pin actually drives, or when the analog function owns it, even if its pullup bit is set. Pin 2 has no input path: it always drives, and its direction bit is stored but unused. A read of the data register returns, bit by bit, the output latch for driving pins and the synchronized pad level for input pins.

Top module: `gpio_pullup_port`

## Requirements
- R1: After reset every register reads 0, pin_oe is 0x04 (only the output-only pin 2 drives) and pin_pull is 0.
- R2: The registers sit at addresses data=0, direction=1, pullup=2, slew=3, drive=4; a write takes effect at the clock edge that samples the strobe, and each register reads back the value written; the slew and drive registers appear unchanged on pin_slew and pin_drive.
- R3: With no peripheral ownership, a pin whose direction bit is 1 has pin_oe set and pin_out equal to its data latch bit; a direction bit of 0 clears pin_oe (except on pin 2).
- R4: A data read returns the latch bit for a pin that drives by its direction (or pin 2) and the synchronized pad level for a pin whose direction bit is 0.
- R5: pin_pull is 1 only where the pullup bit is 1, pin_oe is 0 and ana_own is 0.
- R6: Pin 2 always has pin_oe set, ignores its direction bit, reads back its latch and never has its pullup on.
- R7: Where per_own is 1 (pins other than 2), pin_oe follows per_oe and pin_out follows per_out; on pin 2 per_own switches only pin_out.
- R8: Addresses 5 to 7 read 0 and writes to them change no register.
- R9: A pad level change becomes visible in a data read after exactly two clock edges, not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pin_in | input | 8 | Pad input levels |
| per_own | input | 8 | Shared peripheral owns the pin |
| per_oe | input | 8 | Peripheral output enable |
| per_out | input | 8 | Peripheral output value |
| ana_own | input | 8 | Analog function owns the pin |
| pin_oe | output | 8 | Pad output enable |
| pin_out | output | 8 | Pad output value |
| pin_pull | output | 8 | Pad pullup enable |
| pin_slew | output | 8 | Slew-rate selection bits |
| pin_drive | output | 8 | Drive-strength selection bits |

## Verification
The pin logic is tried with all-input, mixed-direction and all-driving masks against pad patterns chosen so that pin 2's pad level differs from its latch, which tells latch read-back from pad read-back. Patterns with peripheral and analog ownership on chosen pins separate the three pullup kill reasons from one another and show that the override reaches pin 2's value but not its enable. A single pad step sampled after one and after two edges pins down the synchronizer depth.

// File: rtl/gpio_pullup_port.sv
module gpio_pullup_port #(
  parameter int WIDTH    = 8,
  parameter int AW       = 3,
  parameter int OUT_ONLY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pin_in,
  input  logic [WIDTH-1:0] per_own,
  input  logic [WIDTH-1:0] per_oe,
  input  logic [WIDTH-1:0] per_out,
  input  logic [WIDTH-1:0] ana_own,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_pull,
  output logic [WIDTH-1:0] pin_slew,
  output logic [WIDTH-1:0] pin_drive
);
  localparam logic [AW-1:0] A_DATA  = AW'(0);
  localparam logic [AW-1:0] A_DIR   = AW'(1);
  localparam logic [AW-1:0] A_PULL  = AW'(2);
  localparam logic [AW-1:0] A_SLEW  = AW'(3);
  localparam logic [AW-1:0] A_DRIVE = AW'(4);
  localparam logic [WIDTH-1:0] OMASK = WIDTH'(1) << OUT_ONLY;

  logic [WIDTH-1:0] data_q, dir_q, pull_q, slew_q, drive_q;
  logic [WIDTH-1:0] sync1_q, sync2_q;
  logic [WIDTH-1:0] port_dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      dir_q   <= '0;
      pull_q  <= '0;
      slew_q  <= '0;
      drive_q <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_DATA:  data_q  <= bus_wdata;
        A_DIR:   dir_q   <= bus_wdata;
        A_PULL:  pull_q  <= bus_wdata;
        A_SLEW:  slew_q  <= bus_wdata;
        A_DRIVE: drive_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  assign port_dir = dir_q | OMASK;

  assign pin_oe   = ((per_own & per_oe) | (~per_own & port_dir)) | OMASK;
  assign pin_out  = (per_own & per_out) | (~per_own & data_q);
  assign pin_pull = pull_q & ~pin_oe & ~ana_own;
  assign pin_slew  = slew_q;
  assign pin_drive = drive_q;

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = (port_dir & data_q) | (~port_dir & sync2_q);
      A_DIR:   bus_rdata = dir_q;
      A_PULL:  bus_rdata = pull_q;
      A_SLEW:  bus_rdata = slew_q;
      A_DRIVE: bus_rdata = drive_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

module gpio_pullup_port_chk #(
  parameter int WIDTH    = 8,
  parameter int AW       = 3,
  parameter int OUT_ONLY = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_we,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] per_own,
  input logic [WIDTH-1:0] per_oe,
  input logic [WIDTH-1:0] ana_own,
  input logic [WIDTH-1:0] pin_oe,
  input logic [WIDTH-1:0] pin_pull
);
  localparam logic [WIDTH-1:0] OMASK = WIDTH'(1) << OUT_ONLY;

  assert_pull_off_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pull & pin_oe) == '0);
  assert_pull_off_analog_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pull & ana_own) == '0);
  assert_out_only_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & OMASK) == OMASK);
  assert_override_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe ^ per_oe) & per_own & ~OMASK) == '0);
  assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(1)) |=>
      (per_own != '0) || ((pin_oe & ~OMASK) == ($past(bus_wdata) & ~OMASK)));
endmodule

bind gpio_pullup_port gpio_pullup_port_chk #(.WIDTH(WIDTH), .AW(AW), .OUT_ONLY(OUT_ONLY)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .per_own(per_own), .per_oe(per_oe), .ana_own(ana_own), .pin_oe(pin_oe), .pin_pull(pin_pull)
);

// File: tb/gpio_pullup_port_test.sv
module gpio_pullup_port_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] bus_addr = '0;
  logic       bus_we = 0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0, per_own = '0, per_oe = '0, per_out = '0, ana_own = '0;
  logic [7:0] pin_oe, pin_out, pin_pull, pin_slew, pin_drive;
  int checks = 0, errors = 0;
  logic [7:0] v;

  always #10 clk = ~clk;

  gpio_pullup_port uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .per_own(per_own), .per_oe(per_oe),
    .per_out(per_out), .ana_own(ana_own), .pin_oe(pin_oe), .pin_out(pin_out),
    .pin_pull(pin_pull), .pin_slew(pin_slew), .pin_drive(pin_drive)
  );

  // dir, data, pad, pullup, own, per_oe, per_out, analog -> oe, out, pull, data read
  typedef logic [7:0] row_t [12];
  localparam row_t VEC [5] = '{
    '{8'h00, 8'hFF, 8'h5A, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h04, 8'hFF, 8'hFB, 8'h5E},
    '{8'hF0, 8'h3C, 8'h0F, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'hF4, 8'h3C, 8'h0B, 8'h3F},
    '{8'h00, 8'h00, 8'hFF, 8'hFF, 8'h81, 8'h80, 8'h81, 8'h10, 8'h84, 8'h81, 8'h6B, 8'hFB},
    '{8'h0F, 8'hA5, 8'h00, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h0F, 8'hA5, 8'h00, 8'h05},
    '{8'h00, 8'h00, 8'hFF, 8'hFF, 8'h04, 8'h00, 8'h04, 8'h00, 8'h04, 8'h04, 8'hFB, 8'hFB}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got hang expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 oe", pin_oe, 8'h04);
    chk("R1 pull", pin_pull, 8'h00);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 reg", v, 8'h00);
    end

    // R3 R4 R5 R6 R7 vector table
    for (int i = 0; i < 5; i++) begin
      wr(3'd1, VEC[i][0]);
      wr(3'd0, VEC[i][1]);
      wr(3'd2, VEC[i][3]);
      pin_in = VEC[i][2]; per_own = VEC[i][4]; per_oe = VEC[i][5];
      per_out = VEC[i][6]; ana_own = VEC[i][7];
      repeat (3) @(negedge clk);
      chk("R3/R7 oe", pin_oe, VEC[i][8]);
      chk("R3/R7 out", pin_out, VEC[i][9]);
      chk("R5 pull", pin_pull, VEC[i][10]);
      rd(3'd0, v);
      chk("R4/R6 data read", v, VEC[i][11]);
    end
    per_own = '0; per_oe = '0; per_out = '0; ana_own = '0;

    // R2 slew/drive storage and read-back
    wr(3'd3, 8'hC3);
    wr(3'd4, 8'h96);
    chk("R2 slew pins", pin_slew, 8'hC3);
    chk("R2 drive pins", pin_drive, 8'h96);
    rd(3'd3, v); chk("R2 slew read", v, 8'hC3);
    rd(3'd4, v); chk("R2 drive read", v, 8'h96);
    rd(3'd1, v); chk("R2 dir read", v, 8'h00);

    // R6 direction bit of pin 2 stored but no effect
    wr(3'd1, 8'h00);
    chk("R6 oe dir0", pin_oe, 8'h04);
    wr(3'd1, 8'h04);
    chk("R6 oe dir1", pin_oe, 8'h04);

    // R8 unmapped addresses
    wr(3'd5, 8'hFF);
    wr(3'd7, 8'hFF);
    rd(3'd5, v); chk("R8 read5", v, 8'h00);
    rd(3'd6, v); chk("R8 read6", v, 8'h00);
    rd(3'd3, v); chk("R8 slew kept", v, 8'hC3);
    rd(3'd1, v); chk("R8 dir kept", v, 8'h04);
    rd(3'd2, v); chk("R8 pull kept", v, 8'hFF);

    // R9 two-edge synchronizer
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h00);
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    pin_in = 8'h81;
    @(negedge clk);
    rd(3'd0, v); chk("R9 one edge", v, 8'h00);
    @(negedge clk);
    rd(3'd0, v); chk("R9 two edges", v, 8'h81);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule